// File: doc/BRIEF.md
# Stream Frame Length Fitter

This block sits inline on a byte-wide packet stream that uses a valid/ready handshake, with a mark on the closing beat of each frame and a per-frame error bit. It forces every frame's length into a window given at run time by a lower and an upper limit input. A frame that ends early has zero bytes appended until it reaches the lower limit. A frame that runs long is closed at the upper limit, and the input bytes beyond that point are accepted and thrown away. The input bytes that are forwarded pass through combinationally, with no register stage in the data path.

After each output frame completes, the block presents one status word on a separate valid/ready handshake. The word holds the input length, the number of bytes actually sent, and two flags that mark a frame as padded or truncated. The next frame is held off until that word has been taken. This lets a downstream consumer log or act on length corrections frame by frame.

Top module: `flen_fitter`

## Requirements
- R1: A frame whose length L lies inside the window is forwarded unchanged: same bytes in the same order, the end mark on byte L, and `m_err` on that byte equal to the input's error bit. Its status reports orig = sent = L with both flags clear.
- R2: A frame whose length L is below the effective lower limit P = min(cfg_min, effective maximum) is forwarded and then extended with bytes of value 0x00 up to P bytes. The end mark sits only on byte P, and `m_err` on that byte carries the input frame's error bit.
- R3: A frame longer than the effective maximum M is cut so that exactly M bytes go out, with the end mark on byte M and `m_err` low. All remaining input bytes, up to and including the input end mark, are accepted and dropped, and the status reports orig = L and sent = M.
- R4: If cfg_max is below cfg_min, the maximum wins and the output length is min(max(L, cfg_min), M). The padded flag is L < cfg_min and the truncated flag is L > M, so both flags can be set for the same frame. A cfg_max of 0 acts as 1.
- R5: Both limits are sampled on the first beat of a frame and held for the rest of it. Changes to the limit inputs after that beat have no effect on that frame.
- R6: The status word appears once per frame, after the output end beat is accepted. It stays stable while `st_ready` is low. Until it is taken, `s_ready` and `m_valid` stay low.
- R7: While padding, `s_ready` is low, and a padding byte advances only on a cycle where `m_ready` is high.
- R8: After reset, `m_valid` and `st_valid` are low while no input is offered, and `s_ready` follows `m_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_min | input | 16 | Lower length limit in bytes |
| cfg_max | input | 16 | Upper length limit in bytes (0 acts as 1) |
| s_data | input | 8 | Input byte |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted when high with s_valid |
| s_last | input | 1 | Input beat closes the frame |
| s_err | input | 1 | Input frame error bit, meaningful on the closing beat |
| m_data | output | 8 | Output byte |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream accepts output beat |
| m_last | output | 1 | Output beat closes the frame |
| m_err | output | 1 | Output frame error bit, set only on the closing beat |
| st_orig | output | 16 | Input length of the reported frame |
| st_sent | output | 16 | Output length of the reported frame |
| st_padded | output | 1 | Input length was below cfg_min |
| st_trunc | output | 1 | Input length exceeded the effective maximum |
| st_valid | output | 1 | Status word valid |
| st_ready | input | 1 | Consumer takes the status word |

## Verification
The output-hold properties assume that the upstream source keeps `s_valid`, `s_data`, `s_last` and `s_err` steady until the beat is accepted. They also assume that the limit inputs do not change while the first beat of a frame waits for `m_ready`. The bench meets both assumptions by driving a beat's fields from its own position counter, which moves only after a handshake. It writes the real limits before a frame's first beat is accepted and scrambles them only after that beat. The sweep covers every combination of lengths 1 to 6 and limits 0 to 6, with and without backpressure on the output and on the status handshake.

// File: rtl/flen_pkg.sv
package flen_pkg;

    localparam int unsigned LEN_W = 16;

    typedef logic [LEN_W-1:0] len_t;

    typedef enum logic [1:0] {
        ST_PASS   = 2'd0,
        ST_PAD    = 2'd1,
        ST_DRAIN  = 2'd2,
        ST_REPORT = 2'd3
    } fl_state_e;

    typedef struct packed {
        len_t orig;
        len_t sent;
        logic padded;
        logic trunc;
    } fl_status_t;

    function automatic len_t len_min(input len_t a, input len_t b);
        return (a < b) ? a : b;
    endfunction

    function automatic len_t len_max(input len_t a, input len_t b);
        return (a > b) ? a : b;
    endfunction

    function automatic len_t len_sat_inc(input len_t a);
        return (a == '1) ? a : a + len_t'(1);
    endfunction

endpackage

// File: rtl/flen_limits.sv
module flen_limits
    import flen_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  len_t cfg_min,
    input  len_t cfg_max,
    input  logic live,
    input  logic capture,
    output len_t lim_min,
    output len_t eff_max,
    output len_t pad_to
);
    len_t min_q, max_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            min_q <= '0;
            max_q <= len_t'(1);
        end else if (capture) begin
            min_q <= cfg_min;
            max_q <= cfg_max;
        end
    end

    len_t raw_max;
    always_comb begin
        lim_min = live ? cfg_min : min_q;
        raw_max = live ? cfg_max : max_q;
        eff_max = len_max(raw_max, len_t'(1));
        pad_to  = len_min(lim_min, eff_max);
    end
endmodule

// File: rtl/flen_ctrl.sv
module flen_ctrl
    import flen_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      s_valid,
    input  logic      s_last,
    input  logic      s_err,
    input  logic      m_ready,
    input  logic      st_ready,
    input  len_t      eff_max,
    input  len_t      pad_to,
    output fl_state_e state,
    output len_t      out_cnt,
    output len_t      in_cnt,
    output logic      live,
    output logic      capture,
    output logic      s_ready,
    output logic      m_valid,
    output logic      m_last,
    output logic      m_err
);
    fl_state_e state_d;
    len_t      out_d, in_d, k;
    logic      pad_err_q, pad_err_d;
    logic      hit_max;

    assign k       = out_cnt + len_t'(1);
    assign hit_max = (k == eff_max);
    assign live    = (state == ST_PASS) && (out_cnt == '0);

    always_comb begin
        state_d   = state;
        out_d     = out_cnt;
        in_d      = in_cnt;
        pad_err_d = pad_err_q;
        capture   = 1'b0;
        s_ready   = 1'b0;
        m_valid   = 1'b0;
        m_last    = 1'b0;
        m_err     = 1'b0;
        unique case (state)
            ST_PASS: begin
                s_ready = m_ready;
                m_valid = s_valid;
                m_last  = hit_max || (s_last && (k >= pad_to));
                m_err   = m_last && s_err && s_last;
                if (s_valid && m_ready) begin
                    out_d   = k;
                    in_d    = len_sat_inc(in_cnt);
                    capture = (out_cnt == '0);
                    if (m_last && s_last) begin
                        state_d = ST_REPORT;
                    end else if (hit_max) begin
                        state_d = ST_DRAIN;
                    end else if (s_last) begin
                        state_d   = ST_PAD;
                        pad_err_d = s_err;
                    end
                end
            end
            ST_PAD: begin
                m_valid = 1'b1;
                m_last  = (k == pad_to);
                m_err   = m_last && pad_err_q;
                if (m_ready) begin
                    out_d = k;
                    if (m_last) state_d = ST_REPORT;
                end
            end
            ST_DRAIN: begin
                s_ready = 1'b1;
                if (s_valid) begin
                    in_d = len_sat_inc(in_cnt);
                    if (s_last) state_d = ST_REPORT;
                end
            end
            ST_REPORT: begin
                if (st_ready) begin
                    state_d = ST_PASS;
                    out_d   = '0;
                    in_d    = '0;
                end
            end
            default: state_d = ST_PASS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_PASS;
            out_cnt   <= '0;
            in_cnt    <= '0;
            pad_err_q <= 1'b0;
        end else begin
            state     <= state_d;
            out_cnt   <= out_d;
            in_cnt    <= in_d;
            pad_err_q <= pad_err_d;
        end
    end
endmodule

// File: rtl/flen_report.sv
module flen_report
    import flen_pkg::*;
(
    input  fl_state_e  state,
    input  len_t       in_cnt,
    input  len_t       out_cnt,
    input  len_t       lim_min,
    input  len_t       eff_max,
    output logic       st_valid,
    output fl_status_t st_word
);
    always_comb begin
        st_valid       = (state == ST_REPORT);
        st_word.orig   = in_cnt;
        st_word.sent   = out_cnt;
        st_word.padded = in_cnt < lim_min;
        st_word.trunc  = in_cnt > eff_max;
    end
endmodule

// File: rtl/flen_fitter.sv
module flen_fitter
    import flen_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LEN_W-1:0]  cfg_min,
    input  logic [LEN_W-1:0]  cfg_max,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic              s_last,
    input  logic              s_err,
    output logic [DATA_W-1:0] m_data,
    output logic              m_valid,
    input  logic              m_ready,
    output logic              m_last,
    output logic              m_err,
    output logic [LEN_W-1:0]  st_orig,
    output logic [LEN_W-1:0]  st_sent,
    output logic              st_padded,
    output logic              st_trunc,
    output logic              st_valid,
    input  logic              st_ready
);
    fl_state_e  state;
    len_t       out_cnt, in_cnt, lim_min, eff_max, pad_to;
    logic       live, capture;
    fl_status_t st_word;

    flen_limits u_limits (
        .clk     (clk),
        .rst     (rst),
        .cfg_min (cfg_min),
        .cfg_max (cfg_max),
        .live    (live),
        .capture (capture),
        .lim_min (lim_min),
        .eff_max (eff_max),
        .pad_to  (pad_to)
    );

    flen_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .s_valid  (s_valid),
        .s_last   (s_last),
        .s_err    (s_err),
        .m_ready  (m_ready),
        .st_ready (st_ready),
        .eff_max  (eff_max),
        .pad_to   (pad_to),
        .state    (state),
        .out_cnt  (out_cnt),
        .in_cnt   (in_cnt),
        .live     (live),
        .capture  (capture),
        .s_ready  (s_ready),
        .m_valid  (m_valid),
        .m_last   (m_last),
        .m_err    (m_err)
    );

    flen_report u_report (
        .state    (state),
        .in_cnt   (in_cnt),
        .out_cnt  (out_cnt),
        .lim_min  (lim_min),
        .eff_max  (eff_max),
        .st_valid (st_valid),
        .st_word  (st_word)
    );

    assign m_data    = (state == ST_PAD) ? '0 : s_data;
    assign st_orig   = st_word.orig;
    assign st_sent   = st_word.sent;
    assign st_padded = st_word.padded;
    assign st_trunc  = st_word.trunc;
endmodule

// File: rtl/flen_fitter_chk.sv
module flen_fitter_chk
    import flen_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input fl_state_e         state,
    input len_t              eff_max,
    input logic              s_ready,
    input logic [DATA_W-1:0] m_data,
    input logic              m_valid,
    input logic              m_ready,
    input logic              m_last,
    input logic              st_valid,
    input logic              st_ready,
    input len_t              st_orig,
    input len_t              st_sent,
    input logic              st_padded,
    input logic              st_trunc
);
    AST_PAD_STALLS_INPUT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PAD) |-> !s_ready); // R7

    AST_PAD_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PAD && m_valid && !m_ready) |=> (m_valid && m_data == '0 && $stable(m_last))); // R7

    AST_REPORT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (st_valid && !st_ready) |=> (st_valid && $stable(st_orig) && $stable(st_sent)
                                     && $stable(st_padded) && $stable(st_trunc))); // R6

    AST_REPORT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        st_valid |-> (!m_valid && !s_ready)); // R6

    AST_SENT_CAPPED: assert property (@(posedge clk) disable iff (rst)
        st_valid |-> (st_sent <= eff_max && st_sent != '0)); // R3

    AST_PAD_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (st_valid && st_sent > st_orig) |-> st_padded); // R2

    AST_TRUNC_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (st_valid && st_orig > st_sent) |-> st_trunc); // R3

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !st_valid); // R8
endmodule

bind flen_fitter flen_fitter_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .state     (state),
    .eff_max   (eff_max),
    .s_ready   (s_ready),
    .m_data    (m_data),
    .m_valid   (m_valid),
    .m_ready   (m_ready),
    .m_last    (m_last),
    .st_valid  (st_valid),
    .st_ready  (st_ready),
    .st_orig   (st_orig),
    .st_sent   (st_sent),
    .st_padded (st_padded),
    .st_trunc  (st_trunc)
);

// File: tb/flen_fitter_tb.sv
module flen_fitter_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_min = '0, cfg_max = '0;
    logic [7:0]  s_data = '0;
    logic        s_valid = 1'b0, s_last = 1'b0, s_err = 1'b0;
    logic        s_ready;
    logic [7:0]  m_data;
    logic        m_valid, m_last, m_err;
    logic        m_ready = 1'b1;
    logic [15:0] st_orig, st_sent;
    logic        st_padded, st_trunc, st_valid;
    logic        st_ready = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    flen_fitter u_dut (
        .clk(clk), .rst(rst), .cfg_min(cfg_min), .cfg_max(cfg_max),
        .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready), .s_last(s_last), .s_err(s_err),
        .m_data(m_data), .m_valid(m_valid), .m_ready(m_ready), .m_last(m_last), .m_err(m_err),
        .st_orig(st_orig), .st_sent(st_sent), .st_padded(st_padded), .st_trunc(st_trunc),
        .st_valid(st_valid), .st_ready(st_ready)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] in_byte(input int fid, input int idx);
        return 8'h80 | 8'((fid * 5 + idx) & 8'h7f);
    endfunction

    task automatic run_frame(input int fid, input int orig, input int mn, input int mx,
                             input bit bp);
        int emax, esent, in_idx, out_idx, cyc;
        bit epad, etr, got, eerr;
        logic [7:0] exp_b;
        emax  = (mx == 0) ? 1 : mx;
        esent = (orig > mn) ? orig : mn;
        if (esent > emax) esent = emax;
        epad  = orig < mn;
        etr   = orig > emax;
        eerr  = (orig <= emax) ? fid[0] : 1'b0;
        in_idx = 0; out_idx = 0; cyc = 0; got = 1'b0;
        while (!got && cyc < 300) begin
            @(negedge clk);
            // R5: real limits only until the first beat is taken, junk afterwards
            cfg_min = (in_idx == 0) ? 16'(mn) : 16'(mn + 4);
            cfg_max = (in_idx == 0) ? 16'(mx) : 16'((mx + 3) % 7);
            s_valid = in_idx < orig;
            s_data  = in_byte(fid, in_idx);
            s_last  = (in_idx == orig - 1);
            s_err   = (in_idx == orig - 1) && fid[0];
            m_ready = bp ? ((cyc % 3) != 1) : 1'b1;
            st_ready = bp ? ((cyc % 4) == 3) : 1'b1;
            #2;
            if (in_idx == orig && out_idx < esent)
                check(!s_ready, "R7", "s_ready while padding", int'(s_ready), 0);
            if (st_valid && !st_ready)
                check(!s_ready && !m_valid, "R6", "stream idle while report pending",
                      int'(s_ready | m_valid), 0);
            if (m_valid && m_ready) begin
                exp_b = (out_idx < orig) ? in_byte(fid, out_idx) : 8'h00;
                check(out_idx < esent, etr ? "R3" : "R1", "extra output beat", out_idx, esent);
                check(m_data == exp_b, (out_idx < orig) ? "R1" : "R2", "output byte",
                      int'(m_data), int'(exp_b));
                check(m_last == (out_idx == esent - 1), etr ? "R3" : "R2", "end mark position",
                      int'(m_last), int'(out_idx == esent - 1));
                check(m_err == ((out_idx == esent - 1) && eerr), etr ? "R3" : "R2", "error bit",
                      int'(m_err), int'((out_idx == esent - 1) && eerr));
                out_idx++;
            end
            if (s_valid && s_ready) in_idx++;
            if (st_valid && st_ready) begin
                got = 1'b1;
                check(st_orig == 16'(orig), "R6", "status orig", int'(st_orig), orig);
                check(st_sent == 16'(esent), "R4", "status sent", int'(st_sent), esent);
                check(st_padded == epad, "R4", "padded flag", int'(st_padded), int'(epad));
                check(st_trunc == etr, "R4", "trunc flag", int'(st_trunc), int'(etr));
                check(out_idx == esent, "R6", "report after output end", out_idx, esent);
                check(in_idx == orig, "R3", "input fully consumed", in_idx, orig);
            end
            cyc++;
        end
        if (!got) check(1'b0, "R6", "status never issued", 0, 1);
        @(negedge clk);
        s_valid = 1'b0;
    endtask

    initial begin
        int fid;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        m_ready = 1'b1;
        #2;
        check(!m_valid, "R8", "m_valid after reset", int'(m_valid), 0);
        check(!st_valid, "R8", "st_valid after reset", int'(st_valid), 0);
        check(s_ready, "R8", "s_ready follows m_ready", int'(s_ready), 1);
        m_ready = 1'b0;
        #1;
        check(!s_ready, "R8", "s_ready follows m_ready low", int'(s_ready), 0);
        fid = 0;
        for (int orig = 1; orig <= 6; orig++)
            for (int mn = 0; mn <= 6; mn++)
                for (int mx = 0; mx <= 6; mx++) begin
                    run_frame(fid, orig, mn, mx, fid[1]);
                    fid++;
                end
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule